// File: doc/BRIEF.md
# Compare Timer with Event Trigger

This block is a small up-counting timer for a low-power subsystem. A single-cycle advance strobe, which stands in for a slow prescaled clock, moves the counter forward while the timer is on. When the counter holds the programmed compare value and an advance strobe arrives, the block raises a sticky compare flag. In the same clock edge it raises an event trigger that other peripherals use without software help. An interrupt line is the flag gated by an interrupt-enable bit.

Software uses a word-addressed register port. Address 0 holds control and status, address 1 holds the compare value and address 2 is the counter view. Software cannot load the counter. A write of any data to address 2 copies the live count into a snapshot, and a read of address 2 always returns that snapshot. The trigger has two behaviours. In the one-shot hold case it stays high after the first match. Otherwise it pulses once per match and drops on the next advance.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, and `irqOut` and `trigOut` are low.
- R2: The counter rises by one on each clock edge where the timer is enabled and `tickIn` is high. It does not move on edges without a strobe, and strobes that arrive while the timer is disabled are lost.
- R3: A write of any data to address 2 copies the live count into the snapshot. A read of address 2 returns the snapshot, which does not follow later increments.
- R4: An advance strobe that arrives while the count equals the compare value (address 1) sets the flag, bit 7 of address 0. The trigger is set at the same clock edge.
- R5: With free-run (bit 2) clear, that advance returns the counter to 0, so the count cycles through 0 to the compare value.
- R6: With free-run set, the counter keeps counting through a match and wraps from its all-ones value to 0.
- R7: If the compare value is nonzero or free-run is set, the trigger is high after a matching advance. It goes low after the next advance that is not a match.
- R8: If the compare value is 0 and free-run is clear, the trigger stays high from the first match until the timer is disabled.
- R9: `irqOut` is high exactly when the interrupt-enable bit (bit 6) and the flag are both set.
- R10: Writing address 0 with bit 7 set clears the flag. Writing it with bit 7 clear leaves the flag as it was. Both apply while the timer keeps running.
- R11: Clearing the enable bit (bit 0) clears the counter, the flag and the trigger. The compare value and the other control bits are kept.
- R12: Address 0 reads back bit 0 as enable, bit 2 as free-run, bit 6 as interrupt enable and bit 7 as the flag. All other bits read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` (combinational) |
| tickIn | input | 1 | Single-cycle counter advance strobe |
| irqOut | output | 1 | Interrupt request |
| trigOut | output | 1 | Event trigger for other peripherals |

## Verification
The bench runs the block with an 8-bit counter. In the periodic case it sweeps several compare values, from 0 up to larger values. After every advance it checks the snapshot count, the trigger, the flag and the interrupt against values computed from the advance number modulo the period. The compare value 0 separates the held trigger from the pulsed one.

A free-running pass goes past the wrap point, which separates wrapping at the all-ones count from restarting at a match. Further patterns cover the following:
- strobes while disabled and idle cycles while enabled
- snapshot stability across later advances
- flag writes with bit 7 set and clear
- a zero compare value with free-run set
- the control read-back mask

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_SNAP = 2'd2;

  localparam int BIT_EN   = 0;
  localparam int BIT_FREE = 2;
  localparam int BIT_IE   = 6;
  localparam int BIT_FLAG = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;      // timer off: hold counter at zero
    logic cntStep;     // advance this edge
    logic cntRestart;  // match in periodic mode: back to zero
    logic cmpLoad;     // compare register write
    logic snapTake;    // capture live count
  } dpCtl_t;

endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [CNT_W-1:0] wrData,
  output logic             cntHit,
  output logic             cmpZero,
  output logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] snapVal
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (dpCtl.cntClr || dpCtl.cntRestart) begin
      cnt <= '0;
    end else if (dpCtl.cntStep) begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal <= '0;
    end else if (dpCtl.cmpLoad) begin
      cmpVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapVal <= '0;
    end else if (dpCtl.snapTake) begin
      snapVal <= cnt;
    end
  end

  assign cntHit  = (cnt == cmpVal);
  assign cmpZero = (cmpVal == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.cntStep && !dpCtl.cntClr && !dpCtl.cntRestart) |=> cnt == $past(cnt) + ONE);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.cntStep && !dpCtl.cntClr) |=> $stable(cnt));
  a_r3_snap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.snapTake |=> $stable(snapVal));
  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.cntRestart |=> cnt == '0);

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       wrEnBit,
  input  logic       wrFreeBit,
  input  logic       wrIeBit,
  input  logic       wrFlagBit,
  input  logic       tickIn,
  input  logic       cntHit,
  input  logic       cmpZero,
  output dpCtl_t     dpCtl,
  output logic [7:0] ctlWord,
  output logic       irqOut,
  output logic       trigOut
);

  logic ctlEn, ctlFree, ctlIe, flag;
  logic wrCtl, enNext, step, hitEvt, latchMode;

  assign wrCtl     = regWrEn && (regAddr == ADDR_CTL);
  assign enNext    = wrCtl ? wrEnBit : ctlEn;
  assign step      = ctlEn && enNext && tickIn;
  assign hitEvt    = step && cntHit;
  assign latchMode = cmpZero && !ctlFree;

  always_comb begin
    dpCtl            = '0;
    dpCtl.cntClr     = !enNext;
    dpCtl.cntStep    = step;
    dpCtl.cntRestart = hitEvt && !ctlFree;
    dpCtl.cmpLoad    = regWrEn && (regAddr == ADDR_CMP);
    dpCtl.snapTake   = regWrEn && (regAddr == ADDR_SNAP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlEn   <= 1'b0;
      ctlFree <= 1'b0;
      ctlIe   <= 1'b0;
    end else begin
      ctlEn <= enNext;
      if (wrCtl) begin
        ctlFree <= wrFreeBit;
        ctlIe   <= wrIeBit;
      end
    end
  end

  // sticky flag: disable clears, a match wins over a software clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (!enNext) begin
      flag <= 1'b0;
    end else if (hitEvt) begin
      flag <= 1'b1;
    end else if (wrCtl && wrFlagBit) begin
      flag <= 1'b0;
    end
  end

  // trigger: held after a match in latch mode, else one advance wide
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigOut <= 1'b0;
    end else if (!enNext) begin
      trigOut <= 1'b0;
    end else if (step) begin
      trigOut <= latchMode ? (trigOut || hitEvt) : hitEvt;
    end
  end

  assign irqOut = ctlIe && flag;

  always_comb begin
    ctlWord           = '0;
    ctlWord[BIT_EN]   = ctlEn;
    ctlWord[BIT_FREE] = ctlFree;
    ctlWord[BIT_IE]   = ctlIe;
    ctlWord[BIT_FLAG] = flag;
  end

  a_r4_flag_trig: assert property (@(posedge clk) disable iff (!rstN)
    hitEvt |=> (flag && trigOut));
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && latchMode && enNext) |=> trigOut);
  a_r11_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEn |-> (!flag && !trigOut));
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && wrFlagBit && !hitEvt) |=> !flag);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [BUS_W-1:0] regWrData,
  output logic [BUS_W-1:0] regRdData,
  input  logic             tickIn,
  output logic             irqOut,
  output logic             trigOut
);

  dpCtl_t           dpCtl;
  logic             cntHit, cmpZero;
  logic [CNT_W-1:0] cmpVal, snapVal;
  logic [7:0]       ctlWord;

  cmp_timer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrEnBit   (regWrData[BIT_EN]),
    .wrFreeBit (regWrData[BIT_FREE]),
    .wrIeBit   (regWrData[BIT_IE]),
    .wrFlagBit (regWrData[BIT_FLAG]),
    .tickIn    (tickIn),
    .cntHit    (cntHit),
    .cmpZero   (cmpZero),
    .dpCtl     (dpCtl),
    .ctlWord   (ctlWord),
    .irqOut    (irqOut),
    .trigOut   (trigOut)
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .wrData  (regWrData[CNT_W-1:0]),
    .cntHit  (cntHit),
    .cmpZero (cmpZero),
    .cmpVal  (cmpVal),
    .snapVal (snapVal)
  );

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTL:  regRdData[7:0]       = ctlWord;
      ADDR_CMP:  regRdData[CNT_W-1:0] = cmpVal;
      ADDR_SNAP: regRdData[CNT_W-1:0] = snapVal;
      default:   regRdData            = '0;
    endcase
  end

endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        tickIn = 1'b0;
  logic        irqOut, trigOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmp_timer #(.BUS_W(16), .CNT_W(8)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tickIn(tickIn),
    .irqOut(irqOut), .trigOut(trigOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tick();
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
  endtask

  task automatic snap(output logic [15:0] v);
    wr(2'd2, 16'hA5C3);
    rd(2'd2, v);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cmpList [5] = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 read", v, 0);
    end
    chk(!irqOut && !trigOut, "R1 outputs", {irqOut, trigOut}, 0);

    // periodic sweep: R4 R5 R7 R8 R9
    foreach (cmpList[i]) begin
      int c = cmpList[i];
      wr(2'd1, 16'(c));
      wr(2'd0, 16'h0041);
      for (int n = 0; n <= 2 * c + 3; n++) begin
        int expC;
        bit expTrig, expFlag;
        if (n > 0) tick();
        expC    = n % (c + 1);
        expTrig = (c == 0) ? (n > 0) : (n > 0 && expC == 0);
        expFlag = (n >= c + 1);
        snap(v);
        chk(v == 16'(expC), "R5 count", v, expC);
        chk(trigOut == expTrig, (c == 0) ? "R8 trig held" : "R7 trig pulse", trigOut, expTrig);
        rd(2'd0, v);
        chk(v[7] == expFlag, "R4 flag", v[7], expFlag);
        chk(irqOut == expFlag, "R9 irq", irqOut, expFlag);
      end
      // R11 disable keeps compare and ie
      wr(2'd0, 16'h0040);
      chk(!trigOut && !irqOut, "R11 outputs off", {trigOut, irqOut}, 0);
      rd(2'd0, v);
      chk(v == 16'h0040, "R11 ctl kept", v, 16'h0040);
      rd(2'd1, v);
      chk(v == 16'(c), "R11 cmp kept", v, c);
      snap(v);
      chk(v == 0, "R11 counter cleared", v, 0);
    end

    // R2 strobes while disabled are lost, idle cycles hold
    wr(2'd1, 16'd100);
    repeat (5) tick();
    wr(2'd0, 16'h0001);
    repeat (10) @(negedge clk);
    snap(v);
    chk(v == 0, "R2 no count", v, 0);
    repeat (4) tick();
    snap(v);
    chk(v == 4, "R2 count", v, 4);

    // R3 snapshot stability
    repeat (3) tick();
    rd(2'd2, v);
    chk(v == 4, "R3 snapshot stable", v, 4);
    snap(v);
    chk(v == 7, "R3 snapshot new", v, 7);
    wr(2'd0, 16'h0000);

    // R6 free-run with wrap, compare 5
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0045);
    for (int n = 1; n <= 260; n++) begin
      bit expTrig;
      tick();
      expTrig = ((n % 256) == 6);
      snap(v);
      chk(v == 16'(n % 256), "R6 free count", v, n % 256);
      chk(trigOut == expTrig, "R7 free trig", trigOut, expTrig);
      chk(irqOut == (n >= 6), "R9 free irq", irqOut, n >= 6);
    end

    // R10 flag write-one-to-clear
    wr(2'd0, 16'h0045);
    rd(2'd0, v);
    chk(v[7] == 1'b1, "R10 write zero keeps flag", v[7], 1);
    wr(2'd0, 16'h00C5);
    rd(2'd0, v);
    chk(v == 16'h0045, "R10 flag cleared", v, 16'h0045);
    chk(!irqOut, "R10 irq low", irqOut, 0);
    snap(v);
    chk(v == 4, "R10 still running", v, 4);
    wr(2'd0, 16'h0000);

    // R7 compare zero with free-run set pulses
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0005);
    tick();
    chk(trigOut == 1'b1, "R7 zero free first", trigOut, 1);
    tick();
    chk(trigOut == 1'b0, "R7 zero free drop", trigOut, 0);

    // R12 control mask and unused address
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v);
    chk(v == 16'h0045, "R12 ctl mask", v, 16'h0045);
    rd(2'd3, v);
    chk(v == 0, "R12 addr3", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule